// File: doc/BRIEF.md
# Keyed Watchdog Reset Sequencer

This block is the control half of a watchdog built around an external 64-bit up-counter. Software writes a 32-bit control word that carries an enable flag and a 16-bit key. A four-state key machine follows those writes. The watchdog becomes armed only after software writes two fixed key values in a set order. From then on, each write must carry one of the two sequence keys. Writing the first key and then the second services the watchdog: the block then asks the external counter to reload to zero. Any other key triggers a reset at once.

While armed, the block also compares the external counter with the external period. When the counter reaches the period, it raises the system reset request. The request is a registered pulse of fixed length. Once the watchdog is armed, software cannot disarm it. Only the hardware reset returns the block to the disabled state. Control writes count only while the timer mode input selects watchdog operation.

Top module: `wdog_key_seq`

## Requirements
- R1: After rst_ni is released, state_o reads 0 (disabled) and both rst_req_o and cnt_clr_o are low.
- R2: State encoding is 0 disabled, 1 enabled, 2 pre-active, 3 active. A write with bit 14 (enable) set moves the disabled state to enabled. A write with bit 14 clear moves the enabled or pre-active state back to disabled.
- R3: In the enabled state, a write with bit 14 set and key 0xA5C6 in bits 31:16 moves the block to pre-active.
- R4: In the pre-active state, a write with bit 14 set and key 0xDA7E moves the block to active. Any other key with bit 14 set returns it to enabled and raises no reset request.
- R5: A write has no effect on state or outputs unless mode_i equals 2.
- R6: Once active, the state stays active whatever is written, including writes with bit 14 clear, until rst_ni is asserted.
- R7: In the active state, a write whose key is neither 0xA5C6 nor 0xDA7E raises rst_req_o on the clock edge that takes the write.
- R8: In the active state, a write of key 0xA5C6 followed by a write of key 0xDA7E gives a one-cycle cnt_clr_o pulse on the edge that takes the second write, with no reset request. A 0xDA7E write that no 0xA5C6 write precedes gives no pulse.
- R9: In the active state, count_i >= period_i raises rst_req_o on the second clock edge after the condition appears. In any other state, the comparison has no effect.
- R10: rst_req_o stays high for exactly 16 consecutive cycles.
- R11: At most one reset pulse is issued per hardware reset. Triggers that come after the first one are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word: key in bits 31:16, enable in bit 14 |
| mode_i | input | 2 | Timer mode; 2 selects watchdog operation |
| count_i | input | 64 | Current value of the external counter |
| period_i | input | 64 | Expiry period of the external counter |
| state_o | output | 2 | Key machine state |
| cnt_clr_o | output | 1 | One-cycle request to reload the counter to zero |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The key machine is driven with correct sequences, with sequences whose key is wrong in each state, with writes that clear the enable bit, and with writes made while the mode is not watchdog. These show apart the state moves that only retreat from the moves that fire a reset. Servicing is tried both as a full key pair and as a lone second key, which shows whether the pair is really tracked. Expiry is raised both in a state below active and in the active state, and the pulse is timed on both of its trigger paths. Triggers repeated after the first pulse show that the block fires only once.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_DIS = 2'd0,
    WD_EN  = 2'd1,
    WD_PRE = 2'd2,
    WD_ACT = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
  import wdog_pkg::*;
#(
  parameter int          KEY_W    = 16,
  parameter logic [15:0] KEY_SEQ0 = 16'hA5C6,
  parameter logic [15:0] KEY_SEQ1 = 16'hDA7E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             en_i,
  output wd_state_e        state_o,
  output logic             svc_clr_o,
  output logic             bad_key_o
);
  wd_state_e state_q, state_d;
  logic      armed_q, armed_d;
  logic      clr_q, clr_d;
  logic      is_k0, is_k1;

  assign is_k0 = (key_i == KEY_SEQ0[KEY_W-1:0]);
  assign is_k1 = (key_i == KEY_SEQ1[KEY_W-1:0]);

  always_comb begin
    state_d   = state_q;
    armed_d   = armed_q;
    clr_d     = 1'b0;
    bad_key_o = 1'b0;
    if (wr_valid_i) begin
      unique case (state_q)
        WD_DIS: if (en_i) state_d = WD_EN;
        WD_EN: begin
          if (!en_i)      state_d = WD_DIS;
          else if (is_k0) state_d = WD_PRE;
        end
        WD_PRE: begin
          if (!en_i)      state_d = WD_DIS;
          else if (is_k1) state_d = WD_ACT;
          else            state_d = WD_EN;
        end
        WD_ACT: begin
          if (is_k0) armed_d = 1'b1;
          else if (is_k1) begin
            clr_d   = armed_q;
            armed_d = 1'b0;
          end else begin
            bad_key_o = 1'b1;
            armed_d   = 1'b0;
          end
        end
        default: state_d = WD_DIS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_DIS;
      armed_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      clr_q   <= clr_d;
    end
  end

  assign state_o   = state_q;
  assign svc_clr_o = clr_q;
endmodule

// File: rtl/wdog_expiry_cmp.sv
module wdog_expiry_cmp #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             expire_o
);
  // registered so the wide compare does not sit in front of the pulse logic
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) expire_o <= 1'b0;
    else         expire_o <= active_i && (count_i >= period_i);
  end
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic req_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LEN = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q;
  logic          spent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      spent_q <= 1'b0;
    end else if (trig_i && !spent_q) begin
      cnt_q   <= LEN;
      spent_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign req_o = (cnt_q != '0);
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
#(
  parameter int          CNT_W     = 64,
  parameter int          KEY_W     = 16,
  parameter int          KEY_LSB   = 16,
  parameter int          EN_BIT    = 14,
  parameter int          MODE_W    = 2,
  parameter int          MODE_WDOG = 2,
  parameter int          PULSE_LEN = 16,
  parameter logic [15:0] KEY_SEQ0  = 16'hA5C6,
  parameter logic [15:0] KEY_SEQ1  = 16'hDA7E
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [KEY_LSB+KEY_W-1:0]  wr_data_i,
  input  logic [MODE_W-1:0]         mode_i,
  input  logic [CNT_W-1:0]          count_i,
  input  logic [CNT_W-1:0]          period_i,
  output logic [1:0]                state_o,
  output logic                      cnt_clr_o,
  output logic                      rst_req_o
);
  wd_state_e  state;
  logic       wr_valid, bad_key, expire;

  assign wr_valid = wr_en_i && (mode_i == MODE_W'(MODE_WDOG));

  wdog_key_fsm #(
    .KEY_W(KEY_W), .KEY_SEQ0(KEY_SEQ0), .KEY_SEQ1(KEY_SEQ1)
  ) i_fsm (
    .clk_i, .rst_ni,
    .wr_valid_i (wr_valid),
    .key_i      (wr_data_i[KEY_LSB +: KEY_W]),
    .en_i       (wr_data_i[EN_BIT]),
    .state_o    (state),
    .svc_clr_o  (cnt_clr_o),
    .bad_key_o  (bad_key)
  );

  wdog_expiry_cmp #(.CNT_W(CNT_W)) i_cmp (
    .clk_i, .rst_ni,
    .active_i (state == WD_ACT),
    .count_i, .period_i,
    .expire_o (expire)
  );

  wdog_pulse_gen #(.PULSE_LEN(PULSE_LEN)) i_pulse (
    .clk_i, .rst_ni,
    .trig_i (bad_key || expire),
    .req_o  (rst_req_o)
  );

  assign state_o = state;
endmodule

// File: rtl/wdog_key_seq_chk.sv
module wdog_key_seq_chk #(
  parameter int PULSE_LEN = 16,
  parameter int MODE_W    = 2,
  parameter int MODE_WDOG = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [1:0]        state_o,
  input logic              cnt_clr_o,
  input logic              rst_req_o
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_cnt;
  logic          fired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      fired  <= 1'b0;
    end else begin
      if (!rst_req_o) hi_cnt <= '0;
      else if (hi_cnt <= HW'(PULSE_LEN)) hi_cnt <= hi_cnt + 1'b1;
      if (hi_cnt != '0 && !rst_req_o) fired <= 1'b1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (state_o == 2'd0));

  assert_mode_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mode_i != MODE_W'(MODE_WDOG)) |=> $stable(state_o));

  assert_no_write_no_move_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(state_o));

  assert_active_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) |=> (state_o == 2'd3));

  assert_clr_in_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_o |-> (state_o == 2'd3));

  assert_req_from_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> (state_o == 2'd3));

  assert_pulse_max_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt <= HW'(PULSE_LEN));

  assert_pulse_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (hi_cnt == HW'(PULSE_LEN)));

  assert_single_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> !fired);
endmodule

bind wdog_key_seq wdog_key_seq_chk #(
  .PULSE_LEN(PULSE_LEN), .MODE_W(MODE_W), .MODE_WDOG(MODE_WDOG)
) i_wdog_key_seq_chk (
  .clk_i, .rst_ni, .wr_en_i, .mode_i, .state_o, .cnt_clr_o, .rst_req_o
);

// File: tb/test_wdog_key_seq.sv
module test_wdog_key_seq;
  localparam logic [15:0] K0 = 16'hA5C6;
  localparam logic [15:0] K1 = 16'hDA7E;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  mode_i = 2'd2;
  logic [63:0] count_i = '0;
  logic [63:0] period_i = 64'hFFFF_0000;
  logic [1:0]  state_o;
  logic        cnt_clr_o, rst_req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  wdog_key_seq i_wdog_key_seq (.*);

  function automatic logic [31:0] wd(logic [15:0] key, logic en);
    return {key, 1'b0, en, 14'h0};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 0; mode_i = 2'd2; count_i = '0; period_i = 64'hFFFF_0000;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic arm();
    hw_reset();
    wr(wd(16'h0, 1)); wr(wd(K0, 1)); wr(wd(K1, 1));
  endtask

  // returns number of consecutive high samples, starting now
  task automatic pulse_len(output int n);
    n = 0;
    while (rst_req_o && n < 40) begin n++; @(negedge clk_i); end
  endtask

  task automatic t_reset();
    hw_reset();
    chk("R1 state", state_o, 0);
    chk("R1 req", rst_req_o, 0);
    chk("R1 clr", cnt_clr_o, 0);
  endtask

  task automatic t_enable();
    hw_reset();
    wr(wd(16'h1234, 0)); chk("R2 no enable stays off", state_o, 0);
    wr(wd(16'h1234, 1)); chk("R2 enable", state_o, 1);
    wr(wd(K0, 0));       chk("R2 clear enable from EN", state_o, 0);
    wr(wd(0, 1)); wr(wd(K0, 1));
    wr(wd(K1, 0));       chk("R2 clear enable from PRE", state_o, 0);
  endtask

  task automatic t_pre();
    hw_reset();
    wr(wd(0, 1));
    wr(wd(K1, 1)); chk("R3 wrong first key stays EN", state_o, 1);
    wr(wd(K0, 1)); chk("R3 pre-active", state_o, 2);
    wr(wd(K1, 1)); chk("R4 active", state_o, 3);
    chk("R4 no reset on arm", rst_req_o, 0);
  endtask

  task automatic t_pre_wrong();
    hw_reset();
    wr(wd(0, 1)); wr(wd(K0, 1));
    wr(wd(16'hBEEF, 1));
    chk("R4 wrong key falls back", state_o, 1);
    chk("R4 no reset", rst_req_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R4 no late reset", rst_req_o, 0);
  endtask

  task automatic t_mode();
    hw_reset();
    mode_i = 2'd1;
    wr(wd(0, 1)); chk("R5 mode1 ignored", state_o, 0);
    mode_i = 2'd2;
    wr(wd(0, 1)); wr(wd(K0, 1)); wr(wd(K1, 1));
    mode_i = 2'd0;
    wr(wd(16'hBAD0, 1));
    chk("R5 bad key ignored in mode0", rst_req_o, 0);
    wr(wd(K0, 1)); wr(wd(K1, 1));
    chk("R5 service ignored in mode0", cnt_clr_o, 0);
    mode_i = 2'd2;
  endtask

  task automatic t_sticky();
    arm();
    wr(wd(K0, 0)); chk("R6 cannot disable", state_o, 3);
    wr(wd(K1, 0)); chk("R6 still active", state_o, 3);
    chk("R6 no reset on valid keys", rst_req_o, 0);
    hw_reset();
    chk("R6 hw reset returns off", state_o, 0);
  endtask

  task automatic t_bad_key();
    int n;
    arm();
    wr(wd(16'h0001, 1));
    chk("R7 reset on bad key", rst_req_o, 1);
    pulse_len(n);
    chk("R10 pulse length bad key", n, 16);
    wr(wd(16'h0002, 1));
    chk("R11 second trigger ignored", rst_req_o, 0);
    count_i = 64'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    chk("R11 expiry after trip ignored", rst_req_o, 0);
    chk("R6 active after reset pulse", state_o, 3);
  endtask

  task automatic t_service();
    arm();
    wr(wd(K1, 1)); chk("R8 lone second key no clear", cnt_clr_o, 0);
    wr(wd(K0, 1)); chk("R8 first key no clear", cnt_clr_o, 0);
    wr(wd(K1, 1)); chk("R8 clear pulse", cnt_clr_o, 1);
    chk("R8 no reset on service", rst_req_o, 0);
    @(negedge clk_i);
    chk("R8 clear one cycle", cnt_clr_o, 0);
    wr(wd(K1, 1)); chk("R8 pair consumed", cnt_clr_o, 0);
  endtask

  task automatic t_expiry();
    int n;
    hw_reset();
    wr(wd(0, 1)); wr(wd(K0, 1));
    period_i = 64'd100; count_i = 64'd200;
    repeat (3) @(negedge clk_i);
    chk("R9 no expiry when pre-active", rst_req_o, 0);
    count_i = 64'd0;
    wr(wd(K1, 1));
    count_i = 64'd99;
    repeat (3) @(negedge clk_i);
    chk("R9 below period", rst_req_o, 0);
    count_i = 64'd100;
    @(negedge clk_i);
    chk("R9 one edge later still low", rst_req_o, 0);
    @(negedge clk_i);
    chk("R9 expiry reset", rst_req_o, 1);
    pulse_len(n);
    chk("R10 pulse length expiry", n, 16);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_pre();
    t_pre_wrong();
    t_mode();
    t_sticky();
    t_bad_key();
    t_service();
    t_expiry();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule